// File: doc/BRIEF.md
# Eight-Channel Sampled Input Port with Staged Completion Flag

This block is the byte-wide register face that a small controller uses to take samples from eight 8-bit input channels. The channel values arrive already digitized. Writing the control register with its start bit set captures the channel named by a 3-bit select field into a data register. The same write can also raise a one-cycle interrupt pulse. A completion flag in the control readback stays set until software reads control and then reads data, in that order.

A second read-only view returns all eight channels at once, one bit per channel. A bit is 1 when its channel is above the mid-scale threshold. Three select lines choose the control register, the data register or this threshold view. Reads return data in the same cycle and have side effects only on the completion state.

Top module: `adc_port_if`

## Requirements
- R1: A control write stores bits 5:0. A control read (sel_ctrl_i with re_i) returns those bits in 5:0 and always returns 0 in bit 6.
- R2: A control write with bit 6 set starts a sample. It copies the channel chosen by control bits 4:2 (channel n sits at ch_i[8n+7:8n]) into the data register. A data read returns that value.
- R3: A start sets the completion state to done-unread. Control readback bit 7 is 1 whenever the state is not idle.
- R4: irq_o is high for exactly the one cycle after a start write that has bit 5 set, and stays low otherwise.
- R5: A control read in done-unread moves the state to control-read. A later data read in control-read returns the state to idle, and bit 7 then reads 0.
- R6: A data read while the state is done-unread leaves the state unchanged.
- R7: After reset the data register holds 0xAA, the stored control bits are 0 and the completion flag is 0.
- R8: A read of the threshold view returns bit i = 1 exactly when channel i is greater than 0x7F.
- R9: Writes to the data register or to the threshold view change neither the data register, the completion state, nor irq_o.
- R10: When a start write and a control read fall in the same cycle, the state becomes done-unread. The read in that cycle returns the old flag.
- R11: The captured sample does not follow later changes of the channel inputs; it changes only on the next start.
- R12: A cycle with re_i low or with no select asserted returns 0 on rdata_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_ctrl_i | input | 1 | Selects the control register |
| sel_data_i | input | 1 | Selects the data register |
| sel_dig_i | input | 1 | Selects the threshold view |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the access cycle |
| ch_i | input | 64 | Eight 8-bit channel values, packed |
| irq_o | output | 1 | Sample-done interrupt pulse |

## Verification
The bench builds the block with its default parameters: eight channels, 8-bit samples, a threshold of 0x7F and a reset sample of 0xAA. With these values every select code in the 3-bit field addresses a real channel. The threshold view fills the whole read byte, so channel values on either side of 0x7F/0x80 decide every bit that is returned. A behavioural model of the completion state and irq_o is compared every clock. This comparison covers the staged clear, the data-read-too-early case and the start that coincides with a control read.

// File: rtl/adc_if_pkg.sv
package adc_if_pkg;
  localparam int BUS_W     = 8;
  localparam int START_BIT = 6;
  localparam int IRQEN_BIT = 5;
  localparam int SEL_LSB   = 2;
  localparam int FLAG_BIT  = 7;
  localparam int KEEP_W    = 6;

  typedef enum logic [1:0] {
    DONE_IDLE      = 2'd0,
    DONE_READ_CTRL = 2'd1,
    DONE_UNREAD    = 2'd2
  } done_e;
endpackage

// File: rtl/adc_ctrl_reg.sv
module adc_ctrl_reg
  import adc_if_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [KEEP_W-1:0] ctrl_o,
  output logic              start_o,
  output logic              irq_o
);
  logic unused_top;
  assign unused_top = wdata_i[BUS_W-1];

  assign start_o = wr_i & wdata_i[START_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '0;
      irq_o  <= 1'b0;
    end else begin
      if (wr_i) ctrl_o <= wdata_i[KEEP_W-1:0];
      irq_o <= start_o & wdata_i[IRQEN_BIT];
    end
  end
endmodule

// File: rtl/adc_sample_cap.sv
module adc_sample_cap #(
  parameter int                NUM_CH    = 8,
  parameter int                DATA_W    = 8,
  parameter logic [DATA_W-1:0] RESET_VAL = 8'hAA,
  localparam int               SEL_W     = $clog2(NUM_CH)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_CH*DATA_W-1:0] ch_i,
  input  logic [SEL_W-1:0]         sel_i,
  input  logic                     capture_i,
  output logic [DATA_W-1:0]        sample_o
);
  logic [DATA_W-1:0] ch_arr [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_unpack
    assign ch_arr[g] = ch_i[g*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sample_o <= RESET_VAL;
    else if (capture_i) sample_o <= ch_arr[sel_i];
  end
endmodule

// File: rtl/adc_done_fsm.sv
module adc_done_fsm
  import adc_if_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  input  logic  rd_ctrl_i,
  input  logic  rd_data_i,
  output done_e state_o
);
  done_e state_d;

  always_comb begin
    state_d = state_o;
    if (start_i)                                   state_d = DONE_UNREAD;
    else if (rd_ctrl_i && state_o == DONE_UNREAD)  state_d = DONE_READ_CTRL;
    else if (rd_data_i && state_o == DONE_READ_CTRL) state_d = DONE_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_o <= DONE_IDLE;
    else         state_o <= state_d;
  end
endmodule

// File: rtl/adc_thresh_view.sv
module adc_thresh_view #(
  parameter int                NUM_CH = 8,
  parameter int                DATA_W = 8,
  parameter logic [DATA_W-1:0] THRESH = 8'h7F
) (
  input  logic [NUM_CH*DATA_W-1:0] ch_i,
  output logic [NUM_CH-1:0]        above_o
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_cmp
    assign above_o[g] = ch_i[g*DATA_W +: DATA_W] > THRESH;
  end
endmodule

// File: rtl/adc_port_if.sv
module adc_port_if
  import adc_if_pkg::*;
#(
  parameter int                NUM_CH    = 8,
  parameter int                DATA_W    = 8,
  parameter logic [DATA_W-1:0] THRESH    = 8'h7F,
  parameter logic [DATA_W-1:0] RESET_VAL = 8'hAA,
  localparam int               SEL_W     = $clog2(NUM_CH)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sel_ctrl_i,
  input  logic                     sel_data_i,
  input  logic                     sel_dig_i,
  input  logic                     we_i,
  input  logic                     re_i,
  input  logic [BUS_W-1:0]         wdata_i,
  output logic [BUS_W-1:0]         rdata_o,
  input  logic [NUM_CH*DATA_W-1:0] ch_i,
  output logic                     irq_o
);
  logic              wr_ctrl, rd_ctrl, rd_data, rd_dig, start;
  logic [KEEP_W-1:0] ctrl_bits;
  logic [DATA_W-1:0] sample;
  logic [NUM_CH-1:0] above;
  done_e             done_state;

  assign wr_ctrl = we_i & sel_ctrl_i;
  assign rd_ctrl = re_i & sel_ctrl_i;
  assign rd_data = re_i & sel_data_i;
  assign rd_dig  = re_i & sel_dig_i;

  adc_ctrl_reg u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_ctrl),
    .wdata_i (wdata_i),
    .ctrl_o  (ctrl_bits),
    .start_o (start),
    .irq_o   (irq_o)
  );

  adc_sample_cap #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .RESET_VAL(RESET_VAL)) u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ch_i      (ch_i),
    .sel_i     (ctrl_sel(wdata_i)),
    .capture_i (start),
    .sample_o  (sample)
  );

  adc_done_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .rd_ctrl_i (rd_ctrl),
    .rd_data_i (rd_data),
    .state_o   (done_state)
  );

  adc_thresh_view #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .THRESH(THRESH)) u_thr (
    .ch_i    (ch_i),
    .above_o (above)
  );

  function automatic logic [SEL_W-1:0] ctrl_sel(input logic [BUS_W-1:0] w);
    return w[SEL_LSB +: SEL_W];
  endfunction

  always_comb begin
    rdata_o = '0;
    if (rd_ctrl) begin
      rdata_o[KEEP_W-1:0] = ctrl_bits;
      rdata_o[FLAG_BIT]   = (done_state != DONE_IDLE);
    end else if (rd_data) begin
      rdata_o = BUS_W'(sample);
    end else if (rd_dig) begin
      rdata_o = BUS_W'(above);
    end
  end
endmodule

// File: rtl/adc_port_if_chk.sv
module adc_port_if_chk
  import adc_if_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_ctrl_i,
  input logic              sel_data_i,
  input logic              we_i,
  input logic              re_i,
  input logic [BUS_W-1:0]  wdata_i,
  input logic [BUS_W-1:0]  rdata_o,
  input logic              irq_o,
  input done_e             done_state_i,
  input logic [DATA_W-1:0] sample_i
);
  logic strt, rc, rd;
  assign strt = we_i & sel_ctrl_i & wdata_i[START_BIT];
  assign rc   = re_i & sel_ctrl_i;
  assign rd   = re_i & sel_data_i;

  assert_bit6_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rc |-> !rdata_o[START_BIT]);

  assert_irq_source_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(strt && wdata_i[IRQEN_BIT]));

  assert_start_unread_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strt |=> done_state_i == DONE_UNREAD);

  assert_ctrl_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rc && !strt && done_state_i == DONE_UNREAD) |=> done_state_i == DONE_READ_CTRL);

  assert_early_data_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && !rc && !strt && done_state_i == DONE_UNREAD) |=> done_state_i == DONE_UNREAD);

  assert_sample_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strt |=> $stable(sample_i));
endmodule

bind adc_port_if adc_port_if_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sel_ctrl_i   (sel_ctrl_i),
  .sel_data_i   (sel_data_i),
  .we_i         (we_i),
  .re_i         (re_i),
  .wdata_i      (wdata_i),
  .rdata_o      (rdata_o),
  .irq_o        (irq_o),
  .done_state_i (done_state),
  .sample_i     (sample)
);

// File: tb/tb_adc_port_if.sv
module tb_adc_port_if;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_ctrl = 0, sel_data = 0, sel_dig = 0, we = 0, re = 0;
  logic [7:0]  wdata = 0;
  logic [7:0]  rdata;
  logic [63:0] ch_flat;
  logic        irq;
  logic [7:0]  ch [8];

  int n_tests = 0, n_fail = 0;

  int     m_state;
  logic [5:0] m_ctrl;
  logic [7:0] m_data;
  logic   m_irq;

  always #10 clk = ~clk;

  always_comb for (int i = 0; i < 8; i++) ch_flat[i*8 +: 8] = ch[i];

  adc_port_if dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_ctrl_i(sel_ctrl), .sel_data_i(sel_data),
    .sel_dig_i(sel_dig), .we_i(we), .re_i(re), .wdata_i(wdata), .rdata_o(rdata),
    .ch_i(ch_flat), .irq_o(irq)
  );

  // reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state <= 0; m_ctrl <= 0; m_data <= 8'hAA; m_irq <= 0;
    end else begin
      m_irq <= 0;
      if (we && sel_ctrl) begin
        m_ctrl <= wdata[5:0];
        if (wdata[6]) begin
          m_data  <= ch[(wdata >> 2) % 8];
          m_state <= 2;
          m_irq   <= wdata[5];
        end
      end
      if (!(we && sel_ctrl && wdata[6])) begin
        if (re && sel_ctrl && m_state == 2)      m_state <= 1;
        else if (re && sel_data && m_state == 1) m_state <= 0;
      end
    end
  end

  function automatic logic [7:0] expect_read();
    logic [7:0] v = 0;
    if (!re) return 0;
    if (sel_ctrl) v = {m_state != 0, 1'b0, m_ctrl};
    else if (sel_data) v = m_data;
    else if (sel_dig) for (int i = 0; i < 8; i++) v[i] = ch[i] > 8'h7F;
    return v;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  // irq compared every cycle (R4)
  always @(negedge clk) if (rst_n) check("R4 irq", {7'd0, irq}, {7'd0, m_irq});

  // kind: 0 ctrl, 1 data, 2 dig, 3 none
  task automatic acc(input int kind, input logic w, input logic r,
                     input logic [7:0] d, input string tag);
    @(negedge clk);
    sel_ctrl = (kind == 0); sel_data = (kind == 1); sel_dig = (kind == 2);
    we = w; re = r; wdata = d;
    #2 check(tag, rdata, expect_read());
    @(negedge clk);
    sel_ctrl = 0; sel_data = 0; sel_dig = 0; we = 0; re = 0; wdata = 0;
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    ch = '{8'h10, 8'h80, 8'h7F, 8'hFF, 8'h00, 8'h81, 8'h55, 8'hC3};
    #45 rst_n = 1;
    acc(0, 0, 1, 0, "R7 ctrl after reset");
    acc(1, 0, 1, 0, "R7 data after reset");
    acc(2, 0, 1, 0, "R8 digital view");
    acc(0, 1, 0, 8'h6C, "R2 start ch3 irq");
    ch[3] = 8'h01;
    acc(1, 0, 1, 0, "R6 data read while unread");
    acc(0, 0, 1, 0, "R11 R3 flag after start");
    acc(1, 0, 1, 0, "R11 held sample R5 clear");
    acc(0, 0, 1, 0, "R5 flag cleared");
    acc(0, 1, 0, 8'h95, "R1 write no start");
    acc(0, 0, 1, 0, "R1 readback bit6 zero");
    acc(0, 1, 0, 8'h44, "R4 start ch1 no irq");
    acc(1, 1, 0, 8'h33, "R9 data write");
    acc(2, 1, 0, 8'h33, "R9 dig write");
    acc(1, 0, 1, 0, "R9 R2 data unchanged");
    acc(0, 1, 1, 8'h78, "R10 start with ctrl read");
    acc(1, 0, 1, 0, "R10 data read keeps flag");
    acc(0, 0, 1, 0, "R10 flag set");
    acc(1, 0, 1, 0, "R2 ch6 sample");
    acc(0, 0, 1, 0, "R5 clear after R10");
    acc(3, 0, 1, 0, "R12 no select");
    acc(0, 0, 0, 0, "R12 no read strobe");
    for (int k = 0; k < 8; k++) begin
      ch = '{8'h80 ^ (k*8'h11), 8'h7F + k[7:0], 8'hFF - k[7:0], k[7:0] * 8'h25,
             8'h80, 8'h7F, 8'h01 << k, 8'hFE >> k};
      acc(2, 0, 1, 0, "R8 digital pattern");
      acc(0, 1, 0, 8'h60 | 8'(k << 2), "R2 R4 start each channel");
      acc(0, 0, 1, 0, "R3 flag");
      acc(1, 0, 1, 0, "R2 sample");
    end
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule